// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a bus master for a small three-wire serial EEPROM that holds sixteen 16-bit words. The host places a 4-bit word address on `wordAddr` and pulses `start`. The block then raises chip select and shifts out a 10-bit read frame on the data-in line, one bit per clock pulse. It clocks in the 16-bit reply from the data-out line, drops chip select and waits out the deselect time. It then returns the word on `wordOut` together with a one-cycle `wordDone` pulse.

The parameter `TICKS_PER_US` gives the number of system clock cycles in one microsecond. Every interval on the serial wires is a minimum cycle count derived from it: the select setup, the data setup before each rising clock edge, the clock high and low phases, and the deselect hold. A second entry point, `stationStart`, runs three reads in a row for word addresses 0, 1 and 2. It packs the results into a 48-bit station address and pulses `stationDone` when all three reads are complete.

Top module: `mwr_reader`

## Requirements
- R1: A read sends exactly 10 frame bits on `eeDi`, most significant bit first, each one valid at a rising edge of `eeSk`. The frame value is 0x180 OR the 4-bit word address, which gives a leading 0, then 1, 1, 0, 0, 0 and the address nibble.
- R2: `eeCs` rises while `eeSk` is low. The first rising edge of `eeSk` comes at least `TICKS_PER_US` cycles after `eeCs` rises. `eeSk` is never high while `eeCs` is low.
- R3: Before each of the 10 frame clock edges, `eeDi` holds its value for at least ceil(0.4·`TICKS_PER_US`) cycles. `eeDi` does not change while `eeSk` is high. Each high phase of `eeSk` lasts at least 2·`TICKS_PER_US` cycles, and so does each low phase between two pulses.
- R4: After the frame, `eeDi` stays low. Each access issues exactly 26 rising edges of `eeSk`.
- R5: On the last 16 clock pulses, the bit on `eeDo` is sampled at the end of each high phase, most significant bit first. The 16 sampled bits form the word presented on `wordOut`.
- R6: `eeCs` falls while `eeSk` is low. `wordOut` and the `wordDone` pulse update no earlier than `TICKS_PER_US` cycles after `eeCs` falls. `wordDone` is high for exactly one cycle per access.
- R7: A `start` pulse that arrives while an access is in progress has no effect. No extra frame is sent, and the result is the word of the access already running.
- R8: A `stationStart` pulse with no access in progress reads words 0, 1 and 2 in that order. Word i provides byte 2i from its upper 8 bits and byte 2i+1 from its lower 8 bits. Byte 0 sits at `stationAddr[47:40]` and byte 5 at `stationAddr[7:0]`. A single-cycle `stationDone` pulse follows the third word. A host `start` given during the sequence is ignored.
- R9: Synchronous active-high `rst` aborts any access. One cycle later `eeCs`, `eeSk` and `eeDi` are all low and no `wordDone` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to read one word |
| wordAddr | input | ADDR_W | Word address, sampled when `start` is accepted |
| stationStart | input | 1 | Single-cycle request to read words 0..2 into the station address |
| eeDo | input | 1 | Serial data from the EEPROM |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| wordOut | output | DATA_W | Last word read |
| wordDone | output | 1 | One-cycle pulse when `wordOut` updates |
| stationAddr | output | STATION_WORDS*DATA_W | Packed station address bytes |
| stationDone | output | 1 | One-cycle pulse when `stationAddr` is complete |

## Verification
The bench builds the block with `TICKS_PER_US` = 4, `ADDR_W` = 4 and `DATA_W` = 16. The EEPROM model therefore serves all sixteen word addresses, and each access takes under 500 cycles. With these values the minimum intervals are only 2, 4 and 8 cycles, so the model measures every interval to the cycle and any shortened phase shows up against the limits computed in the bench. The small word count lets the full address space be swept, along with the ignored-start, station-sequence and mid-access reset cases.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CS_SETUP,
    PH_BIT_SETUP,
    PH_CLK_HIGH,
    PH_CLK_LOW,
    PH_CS_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT
  } seq_t;

  typedef struct packed {
    logic capture;
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic commit;
  } dp_strobe_t;

endpackage

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int CMD_W        = 10,
  parameter int DATA_W       = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  output logic       busy,
  output logic       csOut,
  output logic       skOut,
  output dp_strobe_t strb
);

  localparam int CS_SETUP = TICKS_PER_US;
  localparam int DI_RAW   = (2 * TICKS_PER_US + 4) / 5;
  localparam int DI_SETUP = (DI_RAW < 1) ? 1 : DI_RAW;
  localparam int HALF     = 2 * TICKS_PER_US;
  localparam int CS_HOLD  = TICKS_PER_US;
  localparam int TMR_W    = $clog2(HALF + 1);
  localparam int NBITS    = CMD_W + DATA_W;
  localparam int BIT_W    = $clog2(NBITS + 1);
  localparam int AGE_W    = $clog2(HALF + 2);

  localparam logic [TMR_W-1:0] LD_CS_SETUP = TMR_W'(CS_SETUP - 1);
  localparam logic [TMR_W-1:0] LD_DI_SETUP = TMR_W'(DI_SETUP - 1);
  localparam logic [TMR_W-1:0] LD_HALF     = TMR_W'(HALF - 1);
  localparam logic [TMR_W-1:0] LD_CS_HOLD  = TMR_W'(CS_HOLD - 1);

  phase_t             phase, phaseNext;
  logic [TMR_W-1:0]   timer, timerNext;
  logic [BIT_W-1:0]   bitIdx;
  logic               bitInc, bitClr;
  logic               timerDone;
  logic               inCmd, lastBit;

  assign timerDone = (timer == '0);
  assign inCmd     = (bitIdx < BIT_W'(CMD_W));
  assign lastBit   = (bitIdx == BIT_W'(NBITS - 1));

  always_comb begin
    phaseNext = phase;
    timerNext = timerDone ? timer : timer - 1'b1;
    strb      = '0;
    bitInc    = 1'b0;
    bitClr    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (startIn) begin
          strb.capture = 1'b1;
          phaseNext    = PH_CS_SETUP;
          timerNext    = LD_CS_SETUP;
        end
      end
      PH_CS_SETUP: begin
        if (timerDone) begin
          strb.loadCmd = 1'b1;
          bitClr       = 1'b1;
          phaseNext    = PH_BIT_SETUP;
          timerNext    = LD_DI_SETUP;
        end
      end
      PH_BIT_SETUP: begin
        if (timerDone) begin
          phaseNext = PH_CLK_HIGH;
          timerNext = LD_HALF;
        end
      end
      PH_CLK_HIGH: begin
        if (timerDone) begin
          strb.sampleBit = !inCmd;
          phaseNext      = PH_CLK_LOW;
          timerNext      = LD_HALF;
        end
      end
      PH_CLK_LOW: begin
        if (timerDone) begin
          strb.shiftCmd = inCmd;
          if (lastBit) begin
            phaseNext = PH_CS_HOLD;
            timerNext = LD_CS_HOLD;
          end else begin
            bitInc    = 1'b1;
            phaseNext = PH_BIT_SETUP;
            timerNext = LD_DI_SETUP;
          end
        end
      end
      PH_CS_HOLD: begin
        if (timerDone) begin
          strb.commit = 1'b1;
          phaseNext   = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      timer  <= '0;
      bitIdx <= '0;
    end else begin
      phase <= phaseNext;
      timer <= timerNext;
      if (bitClr)      bitIdx <= '0;
      else if (bitInc) bitIdx <= bitIdx + 1'b1;
    end
  end

  assign busy  = (phase != PH_IDLE);
  assign csOut = (phase == PH_CS_SETUP) || (phase == PH_BIT_SETUP) ||
                 (phase == PH_CLK_HIGH) || (phase == PH_CLK_LOW);
  assign skOut = (phase == PH_CLK_HIGH);

  // Interval watchers used only by the assertions below.
  logic [AGE_W-1:0] csAge, highRun;
  always_ff @(posedge clk) begin
    if (rst) begin
      csAge   <= '0;
      highRun <= '0;
    end else begin
      if (!csOut)              csAge <= '0;
      else if (csAge != '1)    csAge <= csAge + 1'b1;
      if (!skOut)              highRun <= '0;
      else if (highRun != '1)  highRun <= highRun + 1'b1;
    end
  end

  // R2: every clock rise sits at least the select setup after chip select rose
  assert_select_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(skOut) |-> (csAge >= AGE_W'(CS_SETUP)));

  // R3: the clock high phase never ends early
  assert_high_min_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(skOut) |-> (highRun >= AGE_W'(HALF)));

endmodule

// File: rtl/mwr_dpath.sv
module mwr_dpath
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              doIn,
  output logic              diOut,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordDone
);

  localparam int CMD_W = ADDR_W + 6;

  logic [ADDR_W-1:0] addrReg;
  logic [CMD_W-1:0]  cmdSh;
  logic [DATA_W-1:0] dataSh;
  logic [CMD_W-1:0]  frame;

  // leading zero, start bit, read opcode, two pad zeros, address
  assign frame = {4'b0110, 2'b00, addrReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      cmdSh    <= '0;
      dataSh   <= '0;
      wordOut  <= '0;
      wordDone <= 1'b0;
    end else begin
      if (strb.capture)   addrReg <= addrIn;
      if (strb.loadCmd)   cmdSh <= frame;
      else if (strb.shiftCmd) cmdSh <= {cmdSh[CMD_W-2:0], 1'b0};
      if (strb.sampleBit) dataSh <= {dataSh[DATA_W-2:0], doIn};
      if (strb.commit)    wordOut <= dataSh;
      wordDone <= strb.commit;
    end
  end

  assign diOut = cmdSh[CMD_W-1];

  // R4: data-in is low whenever a reply bit is being taken
  assert_di_low_reply_R4: assert property (@(posedge clk) disable iff (rst)
    strb.sampleBit |-> !diOut);

  // R6: the completion pulse lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    wordDone |=> !wordDone);

endmodule

// File: rtl/mwr_station.sv
module mwr_station
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NWORDS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stationStart,
  input  logic                     readerBusy,
  input  logic                     wordDone,
  input  logic [DATA_W-1:0]        wordIn,
  output logic                     seqStart,
  output logic [ADDR_W-1:0]        seqAddr,
  output logic                     seqActive,
  output logic [NWORDS*DATA_W-1:0] stationAddr,
  output logic                     stationDone
);

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  seq_t             sq;
  logic [IDX_W-1:0] idx;
  logic             capt;

  assign capt      = (sq == SQ_WAIT) && wordDone;
  assign seqStart  = (sq == SQ_ISSUE) && !readerBusy;
  assign seqAddr   = ADDR_W'(idx);
  assign seqActive = (sq != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq          <= SQ_IDLE;
      idx         <= '0;
      stationDone <= 1'b0;
    end else begin
      stationDone <= 1'b0;
      unique case (sq)
        SQ_IDLE:  if (stationStart && !readerBusy) begin
                    sq  <= SQ_ISSUE;
                    idx <= '0;
                  end
        SQ_ISSUE: if (!readerBusy) sq <= SQ_WAIT;
        SQ_WAIT:  if (wordDone) begin
                    if (idx == IDX_W'(NWORDS - 1)) begin
                      sq          <= SQ_IDLE;
                      stationDone <= 1'b1;
                    end else begin
                      idx <= idx + 1'b1;
                      sq  <= SQ_ISSUE;
                    end
                  end
        default:  sq <= SQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : gSlot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (rst)                               slotQ <= '0;
      else if (capt && idx == IDX_W'(g))     slotQ <= wordIn;
    end
    assign stationAddr[(NWORDS-1-g)*DATA_W +: DATA_W] = slotQ;
  end

  // R8: the sequence completion pulse lasts a single cycle
  assert_station_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    stationDone |=> !stationDone);

endmodule

// File: rtl/mwr_reader.sv
module mwr_reader
  import mwr_pkg::*;
#(
  parameter int TICKS_PER_US  = 50,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 16,
  parameter int STATION_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [ADDR_W-1:0]               wordAddr,
  input  logic                            stationStart,
  input  logic                            eeDo,
  output logic                            eeCs,
  output logic                            eeSk,
  output logic                            eeDi,
  output logic [DATA_W-1:0]               wordOut,
  output logic                            wordDone,
  output logic [STATION_WORDS*DATA_W-1:0] stationAddr,
  output logic                            stationDone
);

  localparam int CMD_W = ADDR_W + 6;

  dp_strobe_t        strb;
  logic              readerBusy;
  logic              seqStart, seqActive;
  logic [ADDR_W-1:0] seqAddr;
  logic              readStart;
  logic [ADDR_W-1:0] readAddr;

  assign readStart = seqStart | (start & !seqActive);
  assign readAddr  = seqActive ? seqAddr : wordAddr;

  mwr_ctrl #(
    .TICKS_PER_US(TICKS_PER_US),
    .CMD_W       (CMD_W),
    .DATA_W      (DATA_W)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .startIn(readStart),
    .busy   (readerBusy),
    .csOut  (eeCs),
    .skOut  (eeSk),
    .strb   (strb)
  );

  mwr_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .addrIn  (readAddr),
    .doIn    (eeDo),
    .diOut   (eeDi),
    .wordOut (wordOut),
    .wordDone(wordDone)
  );

  mwr_station #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NWORDS(STATION_WORDS)
  ) uStation (
    .clk         (clk),
    .rst         (rst),
    .stationStart(stationStart),
    .readerBusy  (readerBusy),
    .wordDone    (wordDone),
    .wordIn      (wordOut),
    .seqStart    (seqStart),
    .seqAddr     (seqAddr),
    .seqActive   (seqActive),
    .stationAddr (stationAddr),
    .stationDone (stationDone)
  );

  // R3: data-in never moves while the serial clock is high
  assert_di_holds_high_R3: assert property (@(posedge clk) disable iff (rst)
    eeSk |-> $stable(eeDi));

endmodule

// File: tb/mwr_reader_test.sv
module mwr_reader_test;

  localparam int T        = 4;
  localparam int HALF_MIN = 2 * T;
  localparam int DI_MIN   = (2 * T + 4) / 5;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  wordAddr = 4'd0;
  logic        stationStart = 1'b0;
  logic        eeDo = 1'b0;
  logic        eeCs, eeSk, eeDi;
  logic [15:0] wordOut;
  logic        wordDone;
  logic [47:0] stationAddr;
  logic        stationDone;

  mwr_reader #(.TICKS_PER_US(T), .ADDR_W(4), .DATA_W(16), .STATION_WORDS(3)) uut (
    .clk(clk), .rst(rst), .start(start), .wordAddr(wordAddr),
    .stationStart(stationStart), .eeDo(eeDo), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .wordOut(wordOut), .wordDone(wordDone),
    .stationAddr(stationAddr), .stationDone(stationDone)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  function automatic logic [15:0] memWord(input logic [3:0] a);
    return 16'(16'hA53C + 16'h1021 * {12'd0, a});
  endfunction

  // EEPROM model and interval meter
  int cyc = 0;
  int rises = 0, skCnt = 0, diCnt = 0, csCnt = 0;
  int minHigh = 0, minLow = 0, minDiSet = 0, csSetSeen = 0;
  int csFallCyc = 0, lastRises = 0, diHighData = 0, framesSeen = 0;
  logic [9:0]  frame = '0, lastFrame = '0;
  logic [15:0] curWord = '0;
  logic skPrev = 0, csPrev = 0, diPrev = 0, csFellSkHigh = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      skPrev <= 0; csPrev <= 0; diPrev <= 0; eeDo <= 0;
    end else begin
      if (eeCs && !csPrev) begin
        rises <= 0; frame <= '0; minHigh <= 9999; minLow <= 9999;
        minDiSet <= 9999; diHighData <= 0; framesSeen <= framesSeen + 1;
        csCnt <= 1;
      end else begin
        csCnt <= csCnt + 1;
      end
      if (!eeCs && csPrev) begin
        csFallCyc <= cyc; lastRises <= rises; lastFrame <= frame;
        csFellSkHigh <= eeSk; eeDo <= 0;
      end
      if (eeSk != skPrev) begin
        if (eeSk) begin
          if (rises == 0) csSetSeen <= csCnt;
          else if (skCnt < minLow) minLow <= skCnt;
          if (rises < 10) begin
            frame <= {frame[8:0], eeDi};
            if (diCnt < minDiSet) minDiSet <= diCnt;
            if (rises == 9) curWord <= memWord({frame[2:0], eeDi});
          end else begin
            if (eeDi) diHighData <= diHighData + 1;
            if (rises < 26) eeDo <= curWord[25 - rises];
          end
          rises <= rises + 1;
        end else begin
          if (skCnt < minHigh) minHigh <= skCnt;
        end
        skCnt <= 1;
      end else begin
        skCnt <= skCnt + 1;
      end
      if (eeDi != diPrev) diCnt <= 1; else diCnt <= diCnt + 1;
      skPrev <= eeSk; csPrev <= eeCs; diPrev <= eeDi;
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkGe(input string req, input string what,
                         input int act, input int lim);
    checks++;
    if (act < lim) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc == WATCHDOG && !ended) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finishRun();
    end
  end

  task automatic pulseStart(input logic [3:0] a);
    @(negedge clk);
    wordAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req, output bit seen);
    int n = 0;
    seen = 0;
    while (!wordDone && n < 3000) begin
      @(negedge clk);
      n++;
    end
    seen = wordDone;
    checkEq(req, "done arrives", {63'd0, wordDone}, 64'd1);
  endtask

  task automatic readAndCheck(input logic [3:0] a);
    bit seen;
    int doneCyc;
    pulseStart(a);
    waitDone("R5", seen);
    doneCyc = cyc;
    checkEq("R5", "word", {48'd0, wordOut}, {48'd0, memWord(a)});
    checkEq("R1", "frame", {54'd0, lastFrame}, {54'd0, (10'h180 | {6'd0, a})});
    checkEq("R4", "rise count", 64'(lastRises), 64'd26);
    checkEq("R4", "di high in reply", 64'(diHighData), 64'd0);
    checkGe("R2", "select setup", csSetSeen, T);
    checkGe("R3", "di setup", minDiSet, DI_MIN);
    checkGe("R3", "clock high", minHigh, HALF_MIN);
    checkGe("R3", "clock low", minLow, HALF_MIN);
    checkEq("R6", "cs fell with clock low", {63'd0, csFellSkHigh}, 64'd0);
    checkGe("R6", "deselect hold", doneCyc - csFallCyc, T);
    @(negedge clk);
    checkEq("R6", "done width", {63'd0, wordDone}, 64'd0);
  endtask

  initial begin
    bit seen;
    int f0;
    int n;
    bit sawDone;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R9", "idle outputs", {59'd0, eeCs, eeSk, eeDi, wordDone, stationDone}, 64'd0);

    // sweep every word address
    for (int a = 0; a < 16; a++) readAndCheck(4'(a));

    // R7: a second start during an access is ignored
    f0 = framesSeen;
    pulseStart(4'd5);
    repeat (60) @(negedge clk);
    pulseStart(4'd9);
    waitDone("R7", seen);
    checkEq("R7", "word of first access", {48'd0, wordOut}, {48'd0, memWord(4'd5)});
    checkEq("R7", "frames sent", 64'(framesSeen - f0), 64'd1);
    checkEq("R7", "frame", {54'd0, lastFrame}, 64'h185);
    repeat (80) @(negedge clk);
    checkEq("R7", "no later frame", 64'(framesSeen - f0), 64'd1);
    checkEq("R7", "select idle", {63'd0, eeCs}, 64'd0);

    // R8: station address sequence, with a host start to be ignored
    f0 = framesSeen;
    @(negedge clk);
    stationStart = 1'b1;
    @(negedge clk);
    stationStart = 1'b0;
    repeat (100) @(negedge clk);
    pulseStart(4'd7);
    n = 0;
    while (!stationDone && n < 6000) begin
      @(negedge clk);
      n++;
    end
    checkEq("R8", "station done", {63'd0, stationDone}, 64'd1);
    checkEq("R8", "station address", {16'd0, stationAddr},
            {16'd0, memWord(4'd0), memWord(4'd1), memWord(4'd2)});
    checkEq("R8", "byte0", {56'd0, stationAddr[47:40]}, {56'd0, memWord(4'd0) >> 8});
    checkEq("R8", "byte5", {56'd0, stationAddr[7:0]}, {56'd0, memWord(4'd2) & 16'h00FF});
    checkEq("R8", "frames", 64'(framesSeen - f0), 64'd3);
    checkEq("R8", "last frame", {54'd0, lastFrame}, 64'h182);
    @(negedge clk);
    checkEq("R8", "station done width", {63'd0, stationDone}, 64'd0);
    repeat (40) @(negedge clk);
    checkEq("R8", "host start dropped", 64'(framesSeen - f0), 64'd3);

    // R9: reset in the middle of an access
    f0 = framesSeen;
    pulseStart(4'd3);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkEq("R9", "abort outputs", {61'd0, eeCs, eeSk, eeDi}, 64'd0);
    sawDone = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (wordDone) sawDone = 1;
    end
    checkEq("R9", "no done after abort", {63'd0, sawDone}, 64'd0);
    checkEq("R9", "no new frame", 64'(framesSeen - f0), 64'd1);
    readAndCheck(4'd12);

    finishRun();
  end

endmodule